// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets a bus host reach a small bank of byte-wide configuration registers for a coil-current driver. It works from SCL and SDA samples that are already synchronized to the system clock. It returns an active-high pull-low enable for the open-drain SDA pad. The register contents come out as plain outputs: a ring-compensation enable, a 10-bit current setpoint, latched fault status, an output-stage mode field and a resonance-frequency code.

Access goes through an 8-bit register pointer. The first data byte of a write transfer loads the pointer. Every later byte, written or read, moves the pointer up by one. This supports single and burst writes, and reads either from a freshly set location or from wherever the pointer was left. The setpoint is split over two addresses. The high bits are only staged, and the working setpoint changes when the low byte lands. Writing 1 to control bit 0 returns the whole bank to its defaults, and that bit always reads back as 0. A short deglitch filter on each line rejects pulses shorter than a set number of clock cycles.

Top module: `i2c_reg_target`

## Requirements
- R1: After START the target compares the 7 bits sent before the direction bit (0 = write, 1 = read) with its own address. On a match it acknowledges. On a mismatch it leaves SDA released and ignores every later byte until the next START.
- R2: In a write transfer the first data byte sets the pointer. Each later byte is stored at the pointed register and the pointer then adds one.
- R3: A read returns the register at the current pointer, including a read with no pointer-setting write before it. While the host acknowledges, the pointer adds one after each byte and the next register follows.
- R4: SDA is sampled on SCL rising. The target pulls SDA low for ACK from the SCL fall after the 8th bit until the next SCL fall. The target changes its SDA drive only after an SCL fall, START or STOP.
- R5: START (SDA falls while SCL is high) restarts address reception from any state, which makes a repeated START a valid substitute for STOP. STOP (SDA rises while SCL is high) returns the target to idle.
- R6: Reset values: address 0x02 = 0x02, 0x03 = 0x00, 0x04 = 0x00, 0x05 = 0x00, 0x06 = 0x00, 0x07 = 0x83, ring enable output 1, setpoint output 0.
- R7: Address 0x03 stores setpoint bits [9:8] in its bits [1:0] and reads zero above them. Address 0x04 stores setpoint bits [7:0].
- R8: The setpoint output changes only when a write to 0x04 completes. It then takes the staged 0x03 bits as its upper part and the written byte as its lower part. A write to 0x03 alone leaves it unchanged.
- R9: In the control register at 0x02, writing bit 0 as 1 restores every register to its reset value, and bit 0 always reads 0. Bit 1 is the ring-compensation enable output. The other bits read 0.
- R10: When the host answers a read byte with NACK, the target releases SDA and sends nothing more until the next START.
- R11: The status register at 0x05 ignores writes. Its bits [4:0] are sticky copies of fault inputs [4:0], and they are cleared by reset or by software reset.
- R12: The mode register at 0x06 keeps bits [4:0] and reads bits [7:5] as 0. Addresses outside 0x02 to 0x07 read 0x00 and ignore writes.
- R13: A change on SCL or SDA that lasts fewer than FILT_LEN clock cycles (default 2) is not seen as a bus event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample (wired bus level) |
| fault_i | input | FAULT_W | Fault event flags, set sticky status bits |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| ring_en_o | output | 1 | Ring-compensation enable (control bit 1) |
| setpoint_o | output | SP_W | Working coil-current setpoint |
| status_o | output | 8 | Latched fault status |
| mode_o | output | 8 | Output-stage mode register |
| freq_o | output | 8 | Resonance-frequency code |

## Verification
The engine is driven with single-byte and burst writes, reads from a just-set pointer and from a left-over pointer, and repeated-START turnarounds between a write and a read. Each pattern separates a different part of the pointer handling. A mismatched address, a host NACK followed by extra clocks, and a one-cycle SDA glitch while SCL is high check that the target does not respond when it should not. Partial setpoint updates (high byte only, then low byte), writes to read-only and unused locations, fault pulses and a software reset check the side effects of each register through the output ports and through read-back.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } tgt_state_t;

   localparam logic [7:0] RA_CTRL  = 8'h02;
   localparam logic [7:0] RA_SP_HI = 8'h03;
   localparam logic [7:0] RA_SP_LO = 8'h04;
   localparam logic [7:0] RA_STAT  = 8'h05;
   localparam logic [7:0] RA_MODE  = 8'h06;
   localparam logic [7:0] RA_FREQ  = 8'h07;

   localparam int CB_SWRST = 0;
   localparam int CB_RING  = 1;
   localparam int MODE_W   = 5;

   localparam logic       DEF_RING = 1'b1;
   localparam logic [7:0] DEF_FREQ = 8'h83;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int FILT_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   if (FILT_LEN < 0 || FILT_LEN > 64) begin : g_bad_len
      $error("i2c_line_filter: FILT_LEN out of range");
   end

   if (FILT_LEN == 0) begin : g_bypass
      assign filt_o = raw_i;
   end else begin : g_filter
      localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
      logic [CW-1:0] cnt_q;
      logic          f_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q   <= 1'b1;
            cnt_q <= '0;
         end else if (raw_i == f_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            f_q   <= raw_i;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign filt_o = f_q;

      AST_FILT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(f_q) |-> ($past(raw_i) == f_q)); // R13
   end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_ev = scl & scl_q & sda_q & ~sda;
   assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_rt_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR = 7'h0E
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_ev,
   input  logic       stop_ev,
   input  logic       sda_in,
   input  logic [7:0] rd_data,
   output logic [7:0] rd_addr,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic       sda_pull
);
   tgt_state_t state;
   logic [2:0] bit_cnt;
   logic       got8;
   logic [7:0] rx_sh;
   logic [6:0] tx_sh;
   logic       rw_q;
   logic       first_q;
   logic       host_ack;
   logic [7:0] ptr_q;

   assign rd_addr = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         got8     <= 1'b0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         rw_q     <= 1'b0;
         first_q  <= 1'b0;
         host_ack <= 1'b0;
         ptr_q    <= '0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_ev) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            got8     <= 1'b0;
            sda_pull <= 1'b0;
         end else if (stop_ev) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WR: begin
                  if (scl_rise && !got8) begin
                     rx_sh   <= {rx_sh[6:0], sda_in};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) got8 <= 1'b1;
                  end else if (scl_fall && got8) begin
                     got8 <= 1'b0;
                     if (state == ST_ADDR) begin
                        if (rx_sh[7:1] == TGT_ADDR) begin
                           sda_pull <= 1'b1;
                           rw_q     <= rx_sh[0];
                           state    <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        sda_pull <= 1'b1;
                        state    <= ST_WR_ACK;
                        if (first_q) begin
                           ptr_q   <= rx_sh;
                           first_q <= 1'b0;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr_q;
                           wr_data <= rx_sh;
                           ptr_q   <= ptr_q + 8'd1;
                        end
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        tx_sh    <= rd_data[6:0];
                        sda_pull <= ~rd_data[7];
                        bit_cnt  <= '0;
                        state    <= ST_RD;
                     end else begin
                        sda_pull <= 1'b0;
                        first_q  <= 1'b1;
                        state    <= ST_WR;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     state    <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (bit_cnt == 3'd7) begin
                        sda_pull <= 1'b0;
                        ptr_q    <= ptr_q + 8'd1;
                        state    <= ST_RD_ACK;
                     end else begin
                        bit_cnt  <= bit_cnt + 3'd1;
                        sda_pull <= ~tx_sh[6];
                        tx_sh    <= {tx_sh[5:0], 1'b0};
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_in;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        tx_sh    <= rd_data[6:0];
                        sda_pull <= ~rd_data[7];
                        bit_cnt  <= '0;
                        state    <= ST_RD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> $past(scl_fall || start_ev || stop_ev)); // R4

   AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> ($past(rx_sh[7:1]) == TGT_ADDR)); // R1

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr_q == wr_addr + 8'd1)); // R2

   AST_NACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_ACK && scl_fall && !host_ack && !start_ev && !stop_ev)
      |=> (state == ST_IDLE && !sda_pull)); // R10
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
   import i2c_rt_pkg::*;
#(
   parameter int SP_W    = 10,
   parameter int FAULT_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [7:0]         wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [7:0]         rd_addr,
   output logic [7:0]         rd_data,
   input  logic [FAULT_W-1:0] fault_i,
   output logic               ring_en,
   output logic [SP_W-1:0]    setpoint,
   output logic [7:0]         status,
   output logic [7:0]         mode
,  output logic [7:0]         freq
);
   localparam int         HI_W    = SP_W - 8;
   localparam logic [7:0] HI_MASK = 8'((1 << HI_W) - 1);

   if (SP_W < 9 || SP_W > 16) begin : g_bad_sp
      $error("i2c_reg_bank: SP_W must be 9..16");
   end
   if (FAULT_W < 1 || FAULT_W > 8) begin : g_bad_fault
      $error("i2c_reg_bank: FAULT_W must be 1..8");
   end

   logic               ring_q;
   logic [HI_W-1:0]    hi_q;
   logic [7:0]         lo_q;
   logic [SP_W-1:0]    sp_q;
   logic [FAULT_W-1:0] stat_q;
   logic [MODE_W-1:0]  mode_q;
   logic [7:0]         freq_q;
   logic               swrst;

   assign swrst = wr_en && (wr_addr == RA_CTRL) && wr_data[CB_SWRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_q <= DEF_RING;
         hi_q   <= '0;
         lo_q   <= '0;
         sp_q   <= '0;
         stat_q <= '0;
         mode_q <= '0;
         freq_q <= DEF_FREQ;
      end else if (swrst) begin
         ring_q <= DEF_RING;
         hi_q   <= '0;
         lo_q   <= '0;
         sp_q   <= '0;
         stat_q <= '0;
         mode_q <= '0;
         freq_q <= DEF_FREQ;
      end else begin
         stat_q <= stat_q | fault_i;
         if (wr_en) begin
            case (wr_addr)
               RA_CTRL:  ring_q <= wr_data[CB_RING];
               RA_SP_HI: hi_q   <= wr_data[HI_W-1:0];
               RA_SP_LO: begin
                  lo_q <= wr_data;
                  sp_q <= {hi_q, wr_data};
               end
               RA_MODE:  mode_q <= wr_data[MODE_W-1:0];
               RA_FREQ:  freq_q <= wr_data;
               default: ;
            endcase
         end
      end
   end

   logic [7:0] hi_ext, stat_ext, mode_ext, ctrl_ext;

   always_comb begin
      hi_ext   = '0;
      hi_ext[HI_W-1:0] = hi_q;
      stat_ext = '0;
      stat_ext[FAULT_W-1:0] = stat_q;
      mode_ext = '0;
      mode_ext[MODE_W-1:0] = mode_q;
      ctrl_ext = '0;
      ctrl_ext[CB_RING] = ring_q;
   end

   always_comb begin
      case (rd_addr)
         RA_CTRL:  rd_data = ctrl_ext;
         RA_SP_HI: rd_data = hi_ext;
         RA_SP_LO: rd_data = lo_q;
         RA_STAT:  rd_data = stat_ext;
         RA_MODE:  rd_data = mode_ext;
         RA_FREQ:  rd_data = freq_q;
         default:  rd_data = 8'h00;
      endcase
   end

   assign ring_en  = ring_q;
   assign setpoint = sp_q;
   assign status   = stat_ext;
   assign mode     = mode_ext;
   assign freq     = freq_q;

   AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sp_q) |-> $past(wr_en && (wr_addr == RA_SP_LO || (wr_addr == RA_CTRL && wr_data[CB_SWRST])))); // R8

   AST_SWRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      swrst |=> (freq_q == DEF_FREQ && mode_q == '0 && ring_q == DEF_RING && sp_q == '0)); // R9

   AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == RA_SP_HI) |-> ((rd_data & ~HI_MASK) == 8'h00)); // R7

   AST_STAT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RA_STAT && stat_q == '0 && fault_i == '0) |=> (stat_q == '0)); // R11
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
   parameter logic [6:0] TGT_ADDR = 7'h0E,
   parameter int         SP_W     = 10,
   parameter int         FAULT_W  = 5,
   parameter int         FILT_LEN = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [FAULT_W-1:0] fault_i,
   output logic               sda_pull_o,
   output logic               ring_en_o,
   output logic [SP_W-1:0]    setpoint_o,
   output logic [7:0]         status_o,
   output logic [7:0]         mode_o,
   output logic [7:0]         freq_o
);
   logic [1:0] raw_lines, filt_lines;
   assign raw_lines = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw_lines[g]),
         .filt_o (filt_lines[g])
      );
   end

   logic scl_rise, scl_fall, start_ev, stop_ev;

   i2c_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (filt_lines[1]),
      .sda      (filt_lines[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   logic [7:0] rd_data, rd_addr, wr_addr, wr_data;
   logic       wr_en;

   i2c_byte_engine #(.TGT_ADDR(TGT_ADDR)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .sda_in   (filt_lines[0]),
      .rd_data  (rd_data),
      .rd_addr  (rd_addr),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .sda_pull (sda_pull_o)
   );

   i2c_reg_bank #(.SP_W(SP_W), .FAULT_W(FAULT_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .fault_i  (fault_i),
      .ring_en  (ring_en_o),
      .setpoint (setpoint_o),
      .status   (status_o),
      .mode     (mode_o),
      .freq     (freq_o)
   );
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
   localparam logic [6:0] DEV = 7'h0E;
   localparam logic [7:0] AW  = {DEV, 1'b0};
   localparam logic [7:0] AR  = {DEV, 1'b1};
   localparam int         Q   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       scl_drv = 1'b1;
   logic       sda_drv = 1'b1;
   logic [4:0] fault = '0;
   logic       sda_pull, ring_en;
   logic [9:0] setpoint;
   logic [7:0] status, mode, freq;
   wire        sda_line = sda_drv & ~sda_pull;

   i2c_reg_target i_i2c_reg_target (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_drv),
      .sda_i      (sda_line),
      .fault_i    (fault),
      .sda_pull_o (sda_pull),
      .ring_en_o  (ring_en),
      .setpoint_o (setpoint),
      .status_o   (status),
      .mode_o     (mode),
      .freq_o     (freq)
   );

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t       exp_q[$];
   logic [7:0] obs_byte;
   event       obs_ev;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   task automatic qw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_rd(input logic [7:0] v, input string tag);
      exp_t e;
      e.val = v;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         exp_t e;
         @(obs_ev);
         if (exp_q.size() == 0) begin
            check("R3 unexpected read byte", obs_byte, 8'hxx);
         end else begin
            e = exp_q.pop_front();
            check(e.tag, obs_byte, e.val);
         end
      end
   end

   task automatic bus_start();
      sda_drv = 1'b1; qw(Q);
      scl_drv = 1'b1; qw(Q);
      sda_drv = 1'b0; qw(Q);
      scl_drv = 1'b0; qw(Q);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; qw(Q);
      scl_drv = 1'b1; qw(Q);
      sda_drv = 1'b1; qw(Q);
   endtask

   task automatic write_bit(input logic b, input bit glitch);
      sda_drv = b; qw(Q);
      scl_drv = 1'b1; qw(Q);
      if (glitch) begin
         sda_drv = 1'b0; qw(1);
         sda_drv = 1'b1; qw(Q - 1);
      end else begin
         qw(Q);
      end
      scl_drv = 1'b0; qw(Q);
   endtask

   task automatic read_bit(output logic b);
      sda_drv = 1'b1; qw(Q);
      scl_drv = 1'b1; qw(Q);
      b = sda_line; qw(Q);
      scl_drv = 1'b0; qw(Q);
   endtask

   task automatic wb(input logic [7:0] v, input bit exp_ack, input bit chk_rel,
                     input string tag, input int glitch_bit = -1);
      logic b;
      for (int i = 7; i >= 0; i--) write_bit(v[i], i == glitch_bit);
      read_bit(b);
      check(tag, !b, exp_ack);
      if (exp_ack && chk_rel) check("R4 ack released after next fall", sda_pull, 1'b0);
   endtask

   task automatic rb(input bit ack);
      logic [7:0] d;
      logic b;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         read_bit(b);
         d = {d[6:0], b};
      end
      obs_byte = d;
      ->obs_ev;
      write_bit(!ack, 1'b0);
   endtask

   task automatic finish_run();
      qw(4);
      if (exp_q.size() != 0) check("R3 scoreboard drained", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      qw(5);
      rst_n = 1'b1;
      qw(5);
      // R6 reset state
      check("R6 setpoint", setpoint, 10'h000);
      check("R6 ring enable", ring_en, 1'b1);
      check("R6 mode", mode, 8'h00);
      check("R6 freq", freq, 8'h83);
      check("R6 status", status, 8'h00);
      check("R4 idle pull", sda_pull, 1'b0);

      // defined-location burst read over repeated START: R3 R5 R6 R12
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h02, 1, 1, "R2 pointer byte ack");
      bus_start();
      wb(AR, 1, 0, "R5 repeated START address ack");
      expect_rd(8'h02, "R6 reg 0x02");
      expect_rd(8'h00, "R6 reg 0x03");
      expect_rd(8'h00, "R6 reg 0x04");
      expect_rd(8'h00, "R6 reg 0x05");
      expect_rd(8'h00, "R6 reg 0x06");
      expect_rd(8'h83, "R6 reg 0x07");
      expect_rd(8'h00, "R12 unused reg 0x08");
      for (int i = 0; i < 6; i++) rb(1);
      rb(0);
      bus_stop();

      // current-location read: R3
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h06, 1, 1, "R2 pointer byte ack");
      bus_stop();
      bus_start();
      wb(AR, 1, 0, "R3 address ack");
      expect_rd(8'h00, "R3 current location 0x06");
      expect_rd(8'h83, "R3 increment to 0x07");
      rb(1);
      rb(0);
      bus_stop();

      // burst write of both setpoint bytes: R7 R8
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h03, 1, 1, "R2 pointer");
      wb(8'hFF, 1, 1, "R2 data ack");
      wb(8'h5A, 1, 1, "R2 data ack");
      bus_stop();
      check("R8 setpoint after low byte", setpoint, 10'h35A);
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h03, 1, 1, "R2 pointer");
      bus_start();
      wb(AR, 1, 0, "R5 address ack");
      expect_rd(8'h03, "R7 upper bits of 0x03 read zero");
      expect_rd(8'h5A, "R7 low byte 0x04");
      rb(1);
      rb(0);
      bus_stop();

      // high byte alone does not update: R8
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h03, 1, 1, "R2 pointer");
      wb(8'h01, 1, 1, "R2 data ack");
      bus_stop();
      check("R8 setpoint held after high byte only", setpoint, 10'h35A);
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h04, 1, 1, "R2 pointer");
      wb(8'h10, 1, 1, "R2 data ack");
      bus_stop();
      check("R8 setpoint from staged high and new low", setpoint, 10'h110);

      // status read-only, mode mask, freq burst: R2 R11 R12
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h05, 1, 1, "R2 pointer");
      wb(8'hFF, 1, 1, "R11 status write acked");
      wb(8'hFF, 1, 1, "R2 mode write");
      wb(8'h40, 1, 1, "R2 freq write");
      bus_stop();
      check("R11 status ignores write", status, 8'h00);
      check("R12 mode upper bits zero", mode, 8'h1F);
      check("R2 freq via auto-increment", freq, 8'h40);

      // sticky fault capture: R11
      fault = 5'b10010; qw(1);
      fault = 5'b00000; qw(2);
      check("R11 sticky status", status, 8'h12);
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h05, 1, 1, "R2 pointer");
      bus_start();
      wb(AR, 1, 0, "R5 address ack");
      expect_rd(8'h12, "R11 status read back");
      rb(0);
      bus_stop();

      // control: ring enable and software reset: R9
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h02, 1, 1, "R2 pointer");
      wb(8'h00, 1, 1, "R9 ctrl write");
      bus_stop();
      check("R9 ring enable cleared", ring_en, 1'b0);
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h02, 1, 1, "R2 pointer");
      wb(8'h01, 1, 1, "R9 reset request");
      bus_stop();
      check("R9 ring enable default", ring_en, 1'b1);
      check("R9 setpoint default", setpoint, 10'h000);
      check("R9 mode default", mode, 8'h00);
      check("R9 freq default", freq, 8'h83);
      check("R9 status cleared", status, 8'h00);
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h02, 1, 1, "R2 pointer");
      bus_start();
      wb(AR, 1, 0, "R5 address ack");
      expect_rd(8'h02, "R9 reset bit reads zero");
      rb(0);
      bus_stop();

      // foreign address: R1
      bus_start();
      wb({7'h11, 1'b0}, 0, 0, "R1 foreign address not acked");
      wb(8'h06, 0, 0, "R1 later byte not acked");
      wb(8'hAA, 0, 0, "R1 later byte not acked");
      bus_stop();
      check("R1 mode untouched", mode, 8'h00);

      // host NACK ends read: R10
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h07, 1, 1, "R2 pointer");
      bus_start();
      wb(AR, 1, 0, "R5 address ack");
      expect_rd(8'h83, "R10 byte before NACK");
      expect_rd(8'hFF, "R10 bus released after NACK");
      rb(0);
      rb(0);
      bus_stop();

      // one-cycle SDA glitch while SCL high: R13
      bus_start();
      wb(AW, 1, 1, "R1 address ack");
      wb(8'h07, 1, 1, "R2 pointer");
      wb(8'hFF, 1, 1, "R13 glitched byte acked", 3);
      bus_stop();
      check("R13 glitch ignored, write landed", freq, 8'hFF);

      finish_run();
   end
endmodule